// File: doc/BRIEF.md
# Peak-Current On-Time Updater

This block produces the next high-side on-time of a zero-voltage-switching buck phase once per switching cycle. It does not divide. The on-time correction is a fixed gain applied to a peak-current error. The peak current in that error comes from one of two places. It is either the sampled peak current, or an estimate built from the off-time, the output voltage and a stored reciprocal of the inductance. All arithmetic is signed fixed point. The gain is an unsigned number scaled down by `GAIN_SHIFT` bits, so it can be set to values well below unity, which keeps the loop stable.

A controller pulses `start` at each sampling instant with all operands present on the inputs. A small state machine captures the operands and steps through its states. In sampled mode the states are IDLE, ERR, SCALE, SAT and back to IDLE. In estimation mode the path is IDLE, OFFT, EST, ERR, SCALE, SAT and back to IDLE. The transitions are:

- start_sampled (IDLE to ERR)
- start_estimate (IDLE to OFFT)
- offtime_done (OFFT to EST)
- estimate_done (EST to ERR)
- error_done (ERR to SCALE)
- scale_done (SCALE to SAT)
- result_done (SAT to IDLE)

The saturated result appears on `ton_new` together with a one-cycle `valid` strobe.

Top module: `onupd_core`

## Requirements
- R1: The peak reference is computed as 2·`iavg_ref` − `imin_zvs`, with both operands signed two's complement.
- R2: With `est_mode`=0, the error is the peak reference minus the signed `ipeak_sample` captured at `start`.
- R3: The correction is floor((`gain`·error)/2^GAIN_SHIFT), using arithmetic shift of the signed product. The unclamped result is `ton_prev` plus that correction.
- R4: With `est_mode`=1, the off-time is `period` − `ton_prev`. When `period` ≤ `ton_prev` the off-time is 0.
- R5: With `est_mode`=1, the estimated peak is (`vout`·off-time·`inv_l`) >> EST_SHIFT, saturated to the largest positive IW-bit value. It replaces the sampled peak in the error.
- R6: `ton_new` is clamped to the range [`ton_min`, `ton_max`]. If `ton_min` > `ton_max`, `ton_min` wins.
- R7: `valid` is high for exactly one cycle. It rises 4 clock edges after the edge that accepts `start` in sampled mode, and 6 edges after it in estimation mode, counting the accepting edge as 1.
- R8: A `start` pulse that arrives while an update is in progress is ignored. It produces no extra result and does not alter the pending one.
- R9: After reset, `valid`=0 and `ton_new`=0. `ton_new` holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sample strobe that launches one update |
| est_mode | input | 1 | 1 selects the estimated peak current, 0 selects the sampled peak current |
| iavg_ref | input | IW | Signed average-current reference |
| imin_zvs | input | IW | Signed minimum current needed for ZVS |
| gain | input | GW | Unsigned loop gain, scaled by 2^-GAIN_SHIFT |
| ton_prev | input | TW | Previous on-time in clock ticks |
| ipeak_sample | input | IW | Signed sampled peak current |
| period | input | TW | Present switching period in ticks |
| vout | input | VW | Unsigned output voltage |
| inv_l | input | LW | Reciprocal inductance constant |
| ton_min | input | TW | Lower on-time limit |
| ton_max | input | TW | Upper on-time limit |
| ton_new | output | TW | Clamped new on-time |
| valid | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its defaults: IW=12, GW=12, TW=16, VW=12, LW=12, GAIN_SHIFT=8 and EST_SHIFT=12. With these values a gain of 256 is exactly unity, so a single error count maps to a single tick. That makes the floor rounding of negative corrections (R3) and both clamp limits (R6) reachable with small operands. EST_SHIFT=12 is small enough that a modest voltage, off-time and reciprocal drive the estimate into saturation (R5). Other operands give an in-range estimate, and a zero off-time (R4) is also reachable.

// File: rtl/onupd_pkg.sv
package onupd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFFT,
        ST_EST,
        ST_ERR,
        ST_SCALE,
        ST_SAT
    } onupd_state_e;

    localparam int LAT_SAMPLED  = 4;
    localparam int LAT_ESTIMATE = 6;
endpackage

// File: rtl/onupd_estimator.sv
module onupd_estimator #(
    parameter int TW        = 16,
    parameter int VW        = 12,
    parameter int LW        = 12,
    parameter int IW        = 12,
    parameter int EST_SHIFT = 12
) (
    input  logic [TW-1:0]        period,
    input  logic [TW-1:0]        ton,
    output logic [TW-1:0]        toff,
    input  logic [TW-1:0]        toff_q,
    input  logic [VW-1:0]        vout,
    input  logic [LW-1:0]        inv_l,
    output logic signed [IW-1:0] est
);
    localparam int P1W = VW + TW;
    localparam int P2W = P1W + LW;
    localparam logic [IW-1:0] IMAX = {1'b0, {(IW-1){1'b1}}};

    logic [P1W-1:0] p_volt_time;
    logic [P2W-1:0] p_full;
    logic [P2W-1:0] p_shift;

    // Off-time: period minus on-time, floored at zero
    always_comb begin
        if (period > ton) toff = period - ton;
        else              toff = '0;
    end

    // Peak estimate: vout * toff * (1/L), scaled down and saturated
    always_comb begin
        p_volt_time = P1W'(vout) * P1W'(toff_q);
        p_full      = P2W'(p_volt_time) * P2W'(inv_l);
        p_shift     = p_full >> EST_SHIFT;
        if (p_shift > P2W'(IMAX)) est = IMAX;
        else                      est = p_shift[IW-1:0];
    end
endmodule

// File: rtl/onupd_gain_step.sv
module onupd_gain_step #(
    parameter int IW         = 12,
    parameter int GW         = 12,
    parameter int GAIN_SHIFT = 8,
    parameter int EW         = IW + 3,
    parameter int PW         = EW + GW + 1
) (
    input  logic signed [IW-1:0] iavg,
    input  logic signed [IW-1:0] imin,
    input  logic signed [IW-1:0] meas,
    output logic signed [EW-1:0] err,
    input  logic signed [EW-1:0] err_q,
    input  logic [GW-1:0]        gain,
    output logic signed [PW-1:0] delta
);
    localparam int RW = IW + 2;

    logic signed [RW-1:0] pk_ref;
    logic signed [PW-1:0] gain_ext;
    logic signed [PW-1:0] prod;

    // Peak reference and error
    always_comb begin
        pk_ref = (RW'(iavg) <<< 1) - RW'(imin);
        err    = EW'(pk_ref) - EW'(meas);
    end

    // Scaled correction with floor rounding via arithmetic shift
    always_comb begin
        gain_ext = PW'($signed({1'b0, gain}));
        prod     = PW'(err_q) * gain_ext;
        delta    = prod >>> GAIN_SHIFT;
    end
endmodule

// File: rtl/onupd_limiter.sv
module onupd_limiter #(
    parameter int TW           = 16,
    parameter int SW           = 30,
    parameter bit MIN_PRIORITY = 1'b1
) (
    input  logic signed [SW-1:0] sum,
    input  logic [TW-1:0]        lim_lo,
    input  logic [TW-1:0]        lim_hi,
    output logic [TW-1:0]        ton_out
);
    logic signed [SW-1:0] lo_ext;
    logic signed [SW-1:0] hi_ext;
    logic signed [SW-1:0] stage;

    assign lo_ext = SW'({1'b0, lim_lo});
    assign hi_ext = SW'({1'b0, lim_hi});

    generate
        if (MIN_PRIORITY) begin : g_lo_last
            always_comb begin
                stage = sum;
                if (stage > hi_ext) stage = hi_ext;
                if (stage < lo_ext) stage = lo_ext;
            end
        end else begin : g_hi_last
            always_comb begin
                stage = sum;
                if (stage < lo_ext) stage = lo_ext;
                if (stage > hi_ext) stage = hi_ext;
            end
        end
    endgenerate

    assign ton_out = stage[TW-1:0];
endmodule

// File: rtl/onupd_core.sv
module onupd_core
    import onupd_pkg::*;
#(
    parameter int IW         = 12,
    parameter int GW         = 12,
    parameter int TW         = 16,
    parameter int VW         = 12,
    parameter int LW         = 12,
    parameter int GAIN_SHIFT = 8,
    parameter int EST_SHIFT  = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          est_mode,
    input  logic [IW-1:0] iavg_ref,
    input  logic [IW-1:0] imin_zvs,
    input  logic [GW-1:0] gain,
    input  logic [TW-1:0] ton_prev,
    input  logic [IW-1:0] ipeak_sample,
    input  logic [TW-1:0] period,
    input  logic [VW-1:0] vout,
    input  logic [LW-1:0] inv_l,
    input  logic [TW-1:0] ton_min,
    input  logic [TW-1:0] ton_max,
    output logic [TW-1:0] ton_new,
    output logic          valid
);
    localparam int EW = IW + 3;
    localparam int PW = EW + GW + 1;
    localparam int SW = ((PW > TW + 1) ? PW : TW + 1) + 1;

    onupd_state_e state_q, state_d;

    logic                 cap_mode;
    logic signed [IW-1:0] cap_iavg, cap_imin;
    logic [GW-1:0]        cap_gain;
    logic [TW-1:0]        cap_ton, cap_period, cap_min, cap_max;
    logic [VW-1:0]        cap_vout;
    logic [LW-1:0]        cap_invl;

    logic [TW-1:0]        toff_q, toff_c;
    logic signed [IW-1:0] meas_q, est_c;
    logic signed [EW-1:0] err_q, err_c;
    logic signed [PW-1:0] delta_q, delta_c;
    logic signed [SW-1:0] sum_c;
    logic [TW-1:0]        lim_c;
    logic [TW-1:0]        ton_q;
    logic                 valid_q;
    logic [3:0]           lat_cnt;

    onupd_estimator #(
        .TW(TW), .VW(VW), .LW(LW), .IW(IW), .EST_SHIFT(EST_SHIFT)
    ) u_est (
        .period (cap_period),
        .ton    (cap_ton),
        .toff   (toff_c),
        .toff_q (toff_q),
        .vout   (cap_vout),
        .inv_l  (cap_invl),
        .est    (est_c)
    );

    onupd_gain_step #(
        .IW(IW), .GW(GW), .GAIN_SHIFT(GAIN_SHIFT), .EW(EW), .PW(PW)
    ) u_gain (
        .iavg  (cap_iavg),
        .imin  (cap_imin),
        .meas  (meas_q),
        .err   (err_c),
        .err_q (err_q),
        .gain  (cap_gain),
        .delta (delta_c)
    );

    assign sum_c = SW'($signed({1'b0, cap_ton})) + SW'(delta_q);

    onupd_limiter #(
        .TW(TW), .SW(SW), .MIN_PRIORITY(1'b1)
    ) u_lim (
        .sum     (sum_c),
        .lim_lo  (cap_min),
        .lim_hi  (cap_max),
        .ton_out (lim_c)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = est_mode ? ST_OFFT : ST_ERR;
            ST_OFFT:  state_d = ST_EST;
            ST_EST:   state_d = ST_ERR;
            ST_ERR:   state_d = ST_SCALE;
            ST_SCALE: state_d = ST_SAT;
            ST_SAT:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_mode   <= 1'b0;
            cap_iavg   <= '0;
            cap_imin   <= '0;
            cap_gain   <= '0;
            cap_ton    <= '0;
            cap_period <= '0;
            cap_min    <= '0;
            cap_max    <= '0;
            cap_vout   <= '0;
            cap_invl   <= '0;
            toff_q     <= '0;
            meas_q     <= '0;
            err_q      <= '0;
            delta_q    <= '0;
            ton_q      <= '0;
            valid_q    <= 1'b0;
            lat_cnt    <= '0;
        end else begin
            valid_q <= 1'b0;
            if (state_q != ST_IDLE) lat_cnt <= lat_cnt + 4'd1;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cap_mode   <= est_mode;
                        cap_iavg   <= $signed(iavg_ref);
                        cap_imin   <= $signed(imin_zvs);
                        cap_gain   <= gain;
                        cap_ton    <= ton_prev;
                        cap_period <= period;
                        cap_min    <= ton_min;
                        cap_max    <= ton_max;
                        cap_vout   <= vout;
                        cap_invl   <= inv_l;
                        meas_q     <= $signed(ipeak_sample);
                        lat_cnt    <= 4'd1;
                    end
                end
                ST_OFFT:  toff_q  <= toff_c;
                ST_EST:   meas_q  <= est_c;
                ST_ERR:   err_q   <= err_c;
                ST_SCALE: delta_q <= delta_c;
                ST_SAT: begin
                    ton_q   <= lim_c;
                    valid_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ton_new = ton_q;
    assign valid   = valid_q;

    // Assertions
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (lat_cnt == (cap_mode ? 4'(LAT_ESTIMATE) : 4'(LAT_SAMPLED))));

    assert_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && cap_min <= cap_max) |-> (ton_new >= cap_min && ton_new <= cap_max));

    assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(cap_ton) && $stable(cap_mode)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(ton_new));

    assert_est_nonneg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERR && cap_mode) |-> (meas_q >= 0));
endmodule

// File: tb/onupd_core_test.sv
module onupd_core_test;
    localparam int IW = 12, GW = 12, TW = 16, VW = 12, LW = 12;
    localparam int GAIN_SHIFT = 8, EST_SHIFT = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          est_mode = 1'b0;
    logic [IW-1:0] iavg_ref = '0, imin_zvs = '0, ipeak_sample = '0;
    logic [GW-1:0] gain = '0;
    logic [TW-1:0] ton_prev = '0, period = '0, ton_min = '0, ton_max = '0;
    logic [VW-1:0] vout = '0;
    logic [LW-1:0] inv_l = '0;
    logic [TW-1:0] ton_new;
    logic          valid;

    int checks = 0, errors = 0;
    longint cyc = 0;
    longint exp_q[$];
    longint st_q[$];
    int     lat_q[$];
    string  tag_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    onupd_core uut (
        .clk(clk), .rst_n(rst_n), .start(start), .est_mode(est_mode),
        .iavg_ref(iavg_ref), .imin_zvs(imin_zvs), .gain(gain),
        .ton_prev(ton_prev), .ipeak_sample(ipeak_sample), .period(period),
        .vout(vout), .inv_l(inv_l), .ton_min(ton_min), .ton_max(ton_max),
        .ton_new(ton_new), .valid(valid)
    );

    function automatic longint model(input bit m, input longint ia, input longint im,
                                     input longint g, input longint tp, input longint ps,
                                     input longint per, input longint vo, input longint il,
                                     input longint lo, input longint hi);
        longint pref, meas, toff, est, err, d, s;
        pref = 2 * ia - im;                          // R1
        if (m) begin
            toff = (per > tp) ? per - tp : 0;        // R4
            est = (vo * toff * il) >> EST_SHIFT;     // R5
            if (est > 2047) est = 2047;
            meas = est;
        end else meas = ps;                          // R2
        err = pref - meas;
        d = (g * err) >>> GAIN_SHIFT;                // R3
        s = tp + d;
        if (s > hi) s = hi;                          // R6
        if (s < lo) s = lo;
        return s;
    endfunction

    task automatic run(input string tag, input bit m, input int ia, input int im,
                       input int g, input int tp, input int ps, input int per,
                       input int vo, input int il, input int lo, input int hi);
        @(negedge clk);
        est_mode = m; iavg_ref = IW'(ia); imin_zvs = IW'(im); gain = GW'(g);
        ton_prev = TW'(tp); ipeak_sample = IW'(ps); period = TW'(per);
        vout = VW'(vo); inv_l = LW'(il); ton_min = TW'(lo); ton_max = TW'(hi);
        start = 1'b1;
        exp_q.push_back(model(m, ia, im, g, tp, ps, per, vo, il, lo, hi));
        st_q.push_back(cyc + 1);
        lat_q.push_back(m ? 6 : 4);
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8 unexpected result actual=%0d expected=none", ton_new);
            end else begin
                longint e, s;
                int l;
                string t;
                e = exp_q.pop_front(); s = st_q.pop_front();
                l = lat_q.pop_front(); t = tag_q.pop_front();
                checks++;
                if (longint'(ton_new) != e) begin
                    errors++;
                    $display("FAIL %s ton_new actual=%0d expected=%0d", t, ton_new, e);
                end
                checks++;
                if (cyc - s + 1 != longint'(l)) begin
                    errors++;
                    $display("FAIL R7 latency actual=%0d expected=%0d", cyc - s + 1, l);
                end
            end
        end
    end

    // R7: valid pulse width
    logic valid_d = 1'b0;
    always @(negedge clk) begin
        if (rst_n && valid && valid_d) begin
            checks++; errors++;
            $display("FAIL R7 valid width actual=2 expected=1");
        end
        valid_d <= valid;
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                checks++;
                if (valid !== 1'b0 || ton_new !== '0) begin
                    errors++;
                    $display("FAIL R9 reset actual=%0d/%0d expected=0/0", valid, ton_new);
                end
                rst_n = 1'b1;
                // sampled mode
                run("R2", 0, 100, -40, 256, 1000, 200, 0, 0, 0, 100, 5000);
                run("R1", 0, -300, 40, 128, 2000, -500, 0, 0, 0, 100, 5000);
                run("R3", 0, 100, -40, 64, 1000, 241, 0, 0, 0, 100, 5000);
                run("R3", 0, 100, -40, 0, 1234, 900, 0, 0, 0, 100, 5000);
                run("R3", 0, 500, 20, 300, 3000, -700, 0, 0, 0, 100, 60000);
                run("R6", 0, 100, -40, 256, 4990, 200, 0, 0, 0, 100, 5000);
                run("R6", 0, 100, -40, 256, 120, 400, 0, 0, 0, 100, 5000);
                run("R6", 0, 100, -40, 256, 250, 240, 0, 0, 0, 300, 200);
                // R9: hold between results
                checks++;
                if (ton_new != 16'd300) begin
                    errors++;
                    $display("FAIL R9 hold actual=%0d expected=300", ton_new);
                end
                // estimation mode
                run("R5", 1, 150, -40, 256, 1000, 0, 3000, 50, 8, 100, 5000);
                run("R5", 1, 2000, -40, 256, 1000, 0, 3000, 100, 410, 100, 60000);
                run("R4", 1, 150, -40, 256, 1000, 999, 500, 50, 8, 100, 5000);
                run("R4", 1, 150, -40, 256, 1000, 0, 1000, 4000, 4000, 100, 5000);
                // R8: start while busy is ignored
                @(negedge clk);
                est_mode = 0; iavg_ref = 12'd100; imin_zvs = -12'sd40; gain = 12'd256;
                ton_prev = 16'd1000; ipeak_sample = 12'd200; ton_min = 16'd100;
                ton_max = 16'd5000; start = 1'b1;
                exp_q.push_back(64'd1040); st_q.push_back(cyc + 1);
                lat_q.push_back(4); tag_q.push_back("R8");
                @(negedge clk);
                start = 1'b0;
                @(negedge clk);
                ton_prev = 16'd3000; ipeak_sample = 12'd0; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                repeat (12) @(negedge clk);
                checks++;
                if (exp_q.size() != 0 || ton_new != 16'd1040) begin
                    errors++;
                    $display("FAIL R8 busy start actual=%0d expected=1040", ton_new);
                end
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule